// File: doc/BRIEF.md
# IOTLB Page-Range Invalidation Splitter

This block takes one request to invalidate translations for a run of 4 KiB pages that belong to a single domain. It breaks that run into a series of page-selective invalidation commands. Each command covers a naturally aligned block of 2^m pages. The order m of each block is the smallest of three values: the capability limit on the mask, the alignment of the current page number, and floor(log2) of the pages still left. After a configurable number of page-selective steps, any pages still left are covered by one domain-wide invalidation.

The block also accepts domain-wide and global requests. These produce a single command.

Each command goes out on a simple register port. A page step first writes a 64-bit address word and then the 64-bit command word. The block then reads back the busy bit of the command word until hardware clears it, and only then issues the next write. If a poll runs past a cycle limit, a sticky error is raised and the block returns to idle.

The controller is a single state machine with these states:
- IDLE waits for a start.
- ADDR writes the address word.
- CMD writes the command word.
- POLL issues a read.
- CHECK inspects the busy bit that was read back.
- DONE pulses completion.

The transitions are:
- IDLE→ADDR on a page request.
- IDLE→CMD on a domain or global request, or on a page request without the page-selective capability.
- IDLE→DONE on a page request with zero pages.
- ADDR→CMD.
- CMD→POLL.
- POLL→CHECK.
- CHECK→POLL while the busy bit is still set.
- CHECK→IDLE on timeout.
- CHECK→ADDR when the next page step follows.
- CHECK→CMD on the domain fallback.
- CHECK→DONE when the work is finished.
- DONE→IDLE.

Top module: `tlb_inval_splitter`

## Requirements
- R1: After reset the block is idle. `req_busy`, `req_done`, `err_timeout`, `reg_wr_en` and `reg_rd_en` are all low.
- R2: A start is taken only while `req_busy` is low. `req_busy` is high from the next cycle until the cycle after the one-cycle `req_done` pulse. A start while busy is ignored.
- R3: Each page step writes the address word (`reg_wr_sel`=0) one cycle before its command word (`reg_wr_sel`=1). The address word carries the page number in bits 63:12, zeros in bits 11:7, the hint in bit 6 and the mask order in bits 5:0.
- R4: The mask order m is the minimum of three values:
  - the `cap_max_mask` value;
  - the alignment order: the count of trailing zero bits of the page number, or `cap_max_mask` when the page number is zero;
  - floor(log2) of the pages left.
- R5: After each page step the page number advances by 2^m and the remaining count drops by 2^m. The request completes when the count reaches zero.
- R6: At most MAX_STEPS page steps are issued. If pages remain after them, one domain-selective command for the same domain follows, with no address word.
- R7: A page request (`req_kind`=0) with `cap_psi` low becomes a single domain-selective command with no address word.
- R8: The command word has the following fields:
  - bit 63: busy;
  - bits 61:60: granularity, with 01 for global, 10 for domain and 11 for page;
  - bit 49: drain-read, equal to `cap_drain_rd`;
  - bit 48: drain-write, equal to `cap_drain_wr`;
  - bits 47:32: domain id;
  - every other bit: zero.
- R9: A global request (`req_kind`=2 or 3) writes one command word with a domain id field of zero, whatever `req_did` holds. A domain request (`req_kind`=1) writes one domain command.
- R10: After every command write the block raises `reg_rd_en` for one cycle at a time. It writes nothing more until a read returns `reg_rd_busy` low, one cycle after the read.
- R11: If `reg_rd_busy` stays high for more than POLL_LIMIT re-polls, `err_timeout` is set and stays set until reset. The block then drops `req_busy` without a done pulse and accepts new requests.
- R12: A page request with a zero page count pulses `req_done` and makes no port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start a request (taken only when idle) |
| req_kind | input | 2 | 0 page range, 1 domain, 2/3 global |
| req_did | input | DID_W | Domain id |
| req_page | input | 52 | Start page number (address bits 63:12) |
| req_pages | input | CNT_W | Number of pages |
| req_hint | input | 1 | Hint bit for address words |
| cap_psi | input | 1 | Page-selective invalidation supported |
| cap_drain_wr | input | 1 | Drain-write supported |
| cap_drain_rd | input | 1 | Drain-read supported |
| cap_max_mask | input | 6 | Largest allowed mask order |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Sticky poll timeout error |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_sel | output | 1 | 0 address word, 1 command word |
| reg_wr_data | output | 64 | Register write data |
| reg_rd_en | output | 1 | Read command word |
| reg_rd_busy | input | 1 | Busy bit of the word read, valid the cycle after `reg_rd_en` |

## Verification
Page-range patterns separate the three limits on the mask:
- a zero start address with a count that is a power of two exercises the maximum-mask path;
- an odd page number with a short count forces a small block first and a larger one next;
- a well-aligned start under a low capability cap hits the step limit and its domain fallback;
- a cap of zero forces single-page steps.

Domain, global, no-capability and zero-count requests confirm the single-command and no-write paths. Several poll delays, including one that never clears, show the write ordering against the busy bit and the sticky timeout. A start injected mid-request confirms it is dropped.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
    localparam int PAGE_SHIFT   = 12;
    localparam int PG_W         = 64 - PAGE_SHIFT;
    localparam int MASK_W       = 6;
    localparam int BUSY_BIT     = 63;
    localparam int GRAN_LSB     = 60;
    localparam int DRAIN_RD_BIT = 49;
    localparam int DRAIN_WR_BIT = 48;
    localparam int DID_LSB      = 32;
    localparam int HINT_BIT     = 6;

    localparam logic [1:0] GRAN_GLOBAL = 2'b01;
    localparam logic [1:0] GRAN_DOMAIN = 2'b10;
    localparam logic [1:0] GRAN_PAGE   = 2'b11;

    typedef enum logic [1:0] {
        PH_PAGE   = 2'd0,
        PH_DOMAIN = 2'd1,
        PH_GLOBAL = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CMD   = 3'd2,
        ST_POLL  = 3'd3,
        ST_CHECK = 3'd4,
        ST_DONE  = 3'd5
    } state_e;
endpackage

// File: rtl/tlbi_mask_calc.sv
module tlbi_mask_calc
    import tlbi_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic [PG_W-1:0]   page_num,
    input  logic [CNT_W-1:0]  remain,
    input  logic [MASK_W-1:0] max_mask,
    output logic [MASK_W-1:0] mask
);
    logic [MASK_W-1:0] align_ord;
    logic [MASK_W-1:0] count_ord;
    logic              seen;
    logic [MASK_W-1:0] lo;

    // alignment order: lowest set bit of the page number, cap when zero
    always_comb begin
        align_ord = max_mask;
        seen      = 1'b0;
        for (int i = 0; i < PG_W; i++) begin
            if (!seen && page_num[i]) begin
                align_ord = MASK_W'(i);
                seen      = 1'b1;
            end
        end
    end

    // count order: floor(log2(remain))
    always_comb begin
        count_ord = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (remain[i]) count_ord = MASK_W'(i);
        end
    end

    always_comb begin
        lo   = (align_ord < count_ord) ? align_ord : count_ord;
        mask = (lo < max_mask) ? lo : max_mask;
    end
endmodule

// File: rtl/tlbi_poll_timer.sv
module tlbi_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear)            cnt_q <= '0;
        else if (step && !expired) cnt_q <= cnt_q + W'(1);
    end

    p_count_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));
endmodule

// File: rtl/tlb_inval_splitter.sv
module tlb_inval_splitter
    import tlbi_pkg::*;
#(
    parameter int DID_W      = 16,
    parameter int CNT_W      = 20,
    parameter int MAX_STEPS  = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [1:0]        req_kind,
    input  logic [DID_W-1:0]  req_did,
    input  logic [51:0]       req_page,
    input  logic [CNT_W-1:0]  req_pages,
    input  logic              req_hint,
    input  logic              cap_psi,
    input  logic              cap_drain_wr,
    input  logic              cap_drain_rd,
    input  logic [5:0]        cap_max_mask,
    output logic              req_busy,
    output logic              req_done,
    output logic              err_timeout,
    output logic              reg_wr_en,
    output logic              reg_wr_sel,
    output logic [63:0]       reg_wr_data,
    output logic              reg_rd_en,
    input  logic              reg_rd_busy
);
    localparam int STEP_W = $clog2(MAX_STEPS + 1);

    state_e              state_q, state_d;
    phase_e              phase_q;
    logic [DID_W-1:0]    did_q;
    logic [PG_W-1:0]     pg_q;
    logic [CNT_W-1:0]    rem_q;
    logic                hint_q, dw_q, dr_q;
    logic [MASK_W-1:0]   maxm_q, mask_q, mask_c;
    logic [STEP_W-1:0]   steps_q;
    logic                err_q;
    logic                poll_exp;
    logic [CNT_W-1:0]    step_pages;
    logic [CNT_W-1:0]    rem_after;
    logic                last_step;

    tlbi_mask_calc #(.CNT_W(CNT_W)) u_mask (
        .page_num (pg_q),
        .remain   (rem_q),
        .max_mask (maxm_q),
        .mask     (mask_c)
    );

    tlbi_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_CMD),
        .step    (state_q == ST_CHECK && reg_rd_busy),
        .expired (poll_exp)
    );

    assign step_pages = CNT_W'(1) << mask_q;
    assign rem_after  = rem_q - step_pages;
    assign last_step  = (steps_q + STEP_W'(1)) == STEP_W'(MAX_STEPS);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) begin
                    if (req_kind == 2'd0 && cap_psi)
                        state_d = (req_pages == '0) ? ST_DONE : ST_ADDR;
                    else if (req_kind == 2'd0)
                        state_d = ST_CMD;
                    else
                        state_d = ST_CMD;
                end
            end
            ST_ADDR:  state_d = ST_CMD;
            ST_CMD:   state_d = ST_POLL;
            ST_POLL:  state_d = ST_CHECK;
            ST_CHECK: begin
                if (reg_rd_busy)
                    state_d = poll_exp ? ST_IDLE : ST_POLL;
                else if (phase_q == PH_PAGE) begin
                    if (rem_after == '0)  state_d = ST_DONE;
                    else if (last_step)   state_d = ST_CMD;
                    else                  state_d = ST_ADDR;
                end else
                    state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and step datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_GLOBAL;
            did_q   <= '0;
            pg_q    <= '0;
            rem_q   <= '0;
            hint_q  <= 1'b0;
            dw_q    <= 1'b0;
            dr_q    <= 1'b0;
            maxm_q  <= '0;
            mask_q  <= '0;
            steps_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_start) begin
                    did_q   <= req_did;
                    pg_q    <= req_page;
                    rem_q   <= req_pages;
                    hint_q  <= req_hint;
                    dw_q    <= cap_drain_wr;
                    dr_q    <= cap_drain_rd;
                    maxm_q  <= cap_max_mask;
                    steps_q <= '0;
                    if (req_kind == 2'd0)
                        phase_q <= cap_psi ? PH_PAGE : PH_DOMAIN;
                    else if (req_kind == 2'd1)
                        phase_q <= PH_DOMAIN;
                    else
                        phase_q <= PH_GLOBAL;
                end
                ST_ADDR: mask_q <= mask_c;
                ST_CHECK: begin
                    if (reg_rd_busy) begin
                        if (poll_exp) err_q <= 1'b1;
                    end else if (phase_q == PH_PAGE) begin
                        rem_q   <= rem_after;
                        pg_q    <= pg_q + PG_W'(step_pages);
                        steps_q <= steps_q + STEP_W'(1);
                        if (rem_after != '0 && last_step) phase_q <= PH_DOMAIN;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        reg_wr_en   = 1'b0;
        reg_wr_sel  = 1'b0;
        reg_wr_data = '0;
        reg_rd_en   = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                reg_wr_en   = 1'b1;
                reg_wr_data = {pg_q, 5'b0, hint_q, mask_c};
            end
            ST_CMD: begin
                reg_wr_en  = 1'b1;
                reg_wr_sel = 1'b1;
                reg_wr_data[BUSY_BIT]     = 1'b1;
                reg_wr_data[DRAIN_RD_BIT] = dr_q;
                reg_wr_data[DRAIN_WR_BIT] = dw_q;
                unique case (phase_q)
                    PH_PAGE: begin
                        reg_wr_data[GRAN_LSB +: 2]   = GRAN_PAGE;
                        reg_wr_data[DID_LSB +: DID_W] = did_q;
                    end
                    PH_DOMAIN: begin
                        reg_wr_data[GRAN_LSB +: 2]   = GRAN_DOMAIN;
                        reg_wr_data[DID_LSB +: DID_W] = did_q;
                    end
                    default: reg_wr_data[GRAN_LSB +: 2] = GRAN_GLOBAL;
                endcase
            end
            ST_POLL: reg_rd_en = 1'b1;
            default: ;
        endcase
    end

    assign req_busy    = (state_q != ST_IDLE);
    assign req_done    = (state_q == ST_DONE);
    assign err_timeout = err_q;

    p_cmd_follows_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sel) |=> (reg_wr_en && reg_wr_sel));
    p_mask_capped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sel) |-> (reg_wr_data[5:0] <= maxm_q));
    p_block_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> ((CNT_W'(1) << mask_c) <= rem_q));
    p_remaining_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !reg_rd_busy && phase_q == PH_PAGE) |=> (rem_q < $past(rem_q)));
    p_cmd_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel) |-> reg_wr_data[BUSY_BIT]);
    p_global_no_did_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel && reg_wr_data[GRAN_LSB +: 2] == GRAN_GLOBAL)
            |-> (reg_wr_data[DID_LSB +: 16] == 16'd0));
    p_port_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));
    p_no_write_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en) |=> !reg_wr_en);
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> (!req_done && !req_busy));
endmodule

// File: tb/tlb_inval_splitter_bench.sv
`timescale 1ns/1ps
module tlb_inval_splitter_bench;
    localparam int MAXS = 4;
    localparam int PLIM = 16;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] did;
        logic [51:0] page;
        logic [19:0] pages;
        logic        hint, psi, dw, dr;
        logic [5:0]  maxm;
        logic [3:0]  delay;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd5,  52'h0,   20'd8,   1'b1, 1'b1, 1'b1, 1'b0, 6'd9, 4'd0},
        '{2'd0, 16'd7,  52'h3,   20'd5,   1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 4'd2},
        '{2'd0, 16'd3,  52'h100, 20'd300, 1'b1, 1'b1, 1'b0, 1'b1, 6'd4, 4'd1},
        '{2'd0, 16'd11, 52'h40,  20'd16,  1'b1, 1'b0, 1'b1, 1'b1, 6'd9, 4'd0},
        '{2'd1, 16'd9,  52'h0,   20'd0,   1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 4'd3},
        '{2'd2, 16'h55, 52'h0,   20'd0,   1'b0, 1'b1, 1'b1, 1'b1, 6'd9, 4'd0},
        '{2'd0, 16'd2,  52'h10,  20'd0,   1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 4'd0},
        '{2'd0, 16'd4,  52'h7,   20'd3,   1'b0, 1'b1, 1'b0, 1'b1, 6'd0, 4'd1}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R4 zero-start";
            1: return "R5 odd-start";
            2: return "R6 step-limit";
            3: return "R7 no-psi";
            4: return "R9 domain";
            5: return "R9 global";
            6: return "R12 zero-count";
            default: return "R4 cap-zero";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_did = '0;
    logic [51:0] req_page = '0;
    logic [19:0] req_pages = '0;
    logic        req_hint = 1'b0, cap_psi = 1'b0, cap_drain_wr = 1'b0, cap_drain_rd = 1'b0;
    logic [5:0]  cap_max_mask = '0;
    logic        req_busy, req_done, err_timeout;
    logic        reg_wr_en, reg_wr_sel, reg_rd_en;
    logic [63:0] reg_wr_data;
    logic        reg_rd_busy = 1'b0;

    always #2.5 clk = ~clk;

    tlb_inval_splitter #(.DID_W(16), .CNT_W(20), .MAX_STEPS(MAXS), .POLL_LIMIT(PLIM)) u_tlb_inval_splitter (
        .clk, .rst_n, .req_start, .req_kind, .req_did, .req_page, .req_pages, .req_hint,
        .cap_psi, .cap_drain_wr, .cap_drain_rd, .cap_max_mask,
        .req_busy, .req_done, .err_timeout,
        .reg_wr_en, .reg_wr_sel, .reg_wr_data, .reg_rd_en, .reg_rd_busy
    );

    // register port model and write log
    logic        log_clr = 1'b0;
    logic        hw_hold = 1'b0;
    logic [3:0]  hw_delay = '0;
    logic [3:0]  hw_cnt = '0;
    logic        pend = 1'b0;
    int          viol = 0;
    int          log_n = 0;
    logic        log_sel [64];
    logic [63:0] log_data [64];

    always @(posedge clk) begin
        if (log_clr) begin
            log_n <= 0; pend <= 1'b0; viol <= 0; hw_cnt <= '0;
        end else begin
            if (reg_wr_en) begin
                if (log_n < 64) begin
                    log_sel[log_n]  <= reg_wr_sel;
                    log_data[log_n] <= reg_wr_data;
                end
                log_n <= log_n + 1;
                if (pend) viol <= viol + 1;
                if (reg_wr_sel) begin pend <= 1'b1; hw_cnt <= hw_delay; end
            end
            if (reg_rd_en) begin
                reg_rd_busy <= hw_hold || (hw_cnt != 0);
                if (!hw_hold && hw_cnt == 0) pend <= 1'b0;
                if (hw_cnt != 0) hw_cnt <= hw_cnt - 4'd1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    int exp_n;
    logic        exp_sel [64];
    logic [63:0] exp_data [64];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] mkcmd(logic [1:0] gran, logic [15:0] did, logic dr, logic dw);
        logic [63:0] c = '0;
        c[63] = 1'b1; c[61:60] = gran; c[49] = dr; c[48] = dw; c[47:32] = did;
        return c;
    endfunction

    task automatic push(input logic sel, input logic [63:0] d);
        exp_sel[exp_n] = sel; exp_data[exp_n] = d; exp_n++;
    endtask

    // expected write sequence from the requirements
    task automatic build_exp(input vec_t v);
        logic [1:0] k = v.kind;
        logic [51:0] pg = v.page;
        int left = int'(v.pages);
        int al, co, m;
        exp_n = 0;
        if (k == 2'd0 && !v.psi) k = 2'd1;
        if (k == 2'd0) begin
            for (int s = 0; s < MAXS && left > 0; s++) begin
                al = int'(v.maxm);
                if (pg != 0) for (int b = 51; b >= 0; b--) if (pg[b]) al = b;
                co = 0;
                for (int b = 0; b < 20; b++) if ((left >> b) != 0) co = b;
                m = (al < co) ? al : co;
                if (int'(v.maxm) < m) m = int'(v.maxm);
                push(1'b0, {pg, 5'b0, v.hint, 6'(m)});
                push(1'b1, mkcmd(2'b11, v.did, v.dr, v.dw));
                left -= (1 << m);
                pg += 52'(1 << m);
            end
            if (left > 0) push(1'b1, mkcmd(2'b10, v.did, v.dr, v.dw));
        end else if (k == 2'd1)
            push(1'b1, mkcmd(2'b10, v.did, v.dr, v.dw));
        else
            push(1'b1, mkcmd(2'b01, 16'd0, v.dr, v.dw));
    endtask

    task automatic run_req(input vec_t v, input int poke_at, output bit saw_done);
        @(negedge clk); log_clr = 1'b1; hw_delay = v.delay;
        @(negedge clk); log_clr = 1'b0;
        req_kind = v.kind; req_did = v.did; req_page = v.page; req_pages = v.pages;
        req_hint = v.hint; cap_psi = v.psi; cap_drain_wr = v.dw; cap_drain_rd = v.dr;
        cap_max_mask = v.maxm; req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
        chk(req_busy == 1'b1, "R2 busy after start", 64'(req_busy), 64'd1);
        saw_done = req_done;
        for (int c = 0; c < 3000 && !saw_done && req_busy; c++) begin
            if (c == poke_at) begin req_start = 1'b1; req_kind = 2'd2; end
            @(negedge clk); req_start = 1'b0;
            if (req_done) saw_done = 1'b1;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_log(input string tag);
        chk(log_n == exp_n, tag, 64'(log_n), 64'(exp_n));
        for (int j = 0; j < exp_n && j < log_n && j < 64; j++) begin
            chk(log_sel[j] == exp_sel[j] && log_data[j] == exp_data[j],
                {tag, " R3 R8 word"}, log_data[j], exp_data[j]);
        end
        chk(viol == 0, {tag, " R10 write while busy"}, 64'(viol), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({req_busy, req_done, err_timeout, reg_wr_en, reg_rd_en} == 5'b0,
            "R1 reset outputs", 64'({req_busy, req_done, err_timeout, reg_wr_en, reg_rd_en}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            build_exp(VECS[i]);
            run_req(VECS[i], -1, d);
            chk(d, {vtag(i), " R2 done"}, 64'(d), 64'd1);
            chk(!req_busy, {vtag(i), " R2 idle after"}, 64'(req_busy), 64'd0);
            cmp_log(vtag(i));
        end

        // R2: start while busy is ignored
        build_exp(VECS[2]);
        run_req(VECS[2], 3, d);
        chk(d, "R2 refuse done", 64'(d), 64'd1);
        cmp_log("R2 refuse while busy");

        // R11: poll never clears
        hw_hold = 1'b1;
        build_exp(VECS[4]);
        run_req(VECS[4], -1, d);
        chk(!d, "R11 no done on timeout", 64'(d), 64'd0);
        chk(err_timeout, "R11 error set", 64'(err_timeout), 64'd1);
        chk(!req_busy, "R11 back to idle", 64'(req_busy), 64'd0);
        hw_hold = 1'b0;
        build_exp(VECS[5]);
        run_req(VECS[5], -1, d);
        chk(d, "R11 accepts after timeout", 64'(d), 64'd1);
        chk(err_timeout, "R11 error sticky", 64'(err_timeout), 64'd1);
        cmp_log("R11 after timeout");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule